// File: doc/BRIEF.md
# Block-Zeroing ROM Checksum Verifier

This block verifies a bank of read-only program devices after power-up. It steps through the installed devices one at a time, in ascending index order. For each device it reads every byte through a synchronous read port and keeps a running modulo-256 sum. Each device is divided into fixed-size blocks. Each block carries one adjust byte, so that a healthy block sums to zero.

At every block boundary the running sum is compared with zero, and the accumulator then starts over for the next block. A single nonzero block sum stops the walk at once. The block then reports a failure together with the index of the failing device. If every block of every installed device sums to zero, the block reports a pass.

A single-cycle `start` pulse captures the installed-device mask and launches a run. The `done` output rises with exactly one of `pass` or `fail`. All results stay on the outputs until the next `start`.

Top module: `rom_sum_verifier`

## Requirements
- R1: After reset, `done`, `pass`, `fail` and `memRe` are all low.
- R2: Only devices whose bit is set in `devMask` are read. They are read in ascending index order. Within a device, addresses run from 0 to DEV_BYTES-1, one read per cycle with no gaps.
- R3: The sum is taken modulo 256 over each BLK_BYTES-aligned block. The last byte of a block is its adjust byte. When every block sums to zero, the run ends with `done` and `pass` high.
- R4: A change of any single bit in an installed device makes the run end with `done` and `fail` high. `failDev` then carries that device's 3-bit index.
- R5: Once a block sum fails, no further read is issued, and no later device is visited.
- R6: With an empty `devMask`, `done` and `pass` rise one cycle after the cycle in which `start` is taken, and no read is issued.
- R7: On a passing run with n installed devices, `done` rises n*(DEV_BYTES+2)+1 clock edges after the edge that samples `start`.
- R8: `done`, `pass`, `fail` and `failDev` hold their values until the next `start`. That `start` clears `done` on the following cycle.
- R9: `memData` is taken as the byte addressed by `memDev`/`memAddr` in the cycle before, when `memRe` was high.
- R10: Whenever `done` is high, exactly one of `pass` and `fail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches a run |
| devMask | input | NUM_DEV | Installed-device mask, captured at start |
| memRe | output | 1 | Read enable to the ROM bank |
| memDev | output | IDX_W | Device select |
| memAddr | output | ADDR_W | Byte address within the device |
| memData | input | 8 | Read data, one cycle after memRe |
| done | output | 1 | Run finished |
| pass | output | 1 | All checked blocks summed to zero |
| fail | output | 1 | A block sum was nonzero |
| failDev | output | IDX_W | Index of the failing device |

## Verification
The block-end zero test can fall in the same cycle as the device-end handover. This happens when the corrupted byte lies in the final block of a device: the sum is judged in the drain cycle, when the controller would otherwise move on to the next installed device. A second collision occurs when a mid-device block fails in the cycle in which the first address of the next block is already being issued. The bench flips one bit at every address of every device in a small configuration, so both cases are reached. Each case is judged by the reported device index and by whether any read of a later device, or any read at all after the failure, appears on the port.

// File: rtl/rom_sum_pkg.sv
package rom_sum_pkg;
  typedef struct packed {
    logic clrAddr;
    logic clrAcc;
    logic incAddr;
    logic issue;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_READ,
    ST_DRAIN
  } ctrlState_t;
endpackage

// File: rtl/rom_sum_dp.sv
module rom_sum_dp
  import rom_sum_pkg::*;
#(
  parameter int DEV_BYTES = 2048,
  parameter int BLK_BYTES = 512,
  localparam int ADDR_W = $clog2(DEV_BYTES),
  localparam int BLK_W = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              lastAddr,
  output logic              blkBad
);
  logic [ADDR_W-1:0] addrQ;
  logic              vldQ;
  logic              endQ;
  logic [7:0]        accQ;
  logic [7:0]        sumNow;

  // address counter
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAddr) addrQ <= '0;
    else if (stb.incAddr)     addrQ <= addrQ + 1'b1;
  end

  assign memRe    = stb.issue;
  assign memAddr  = addrQ;
  assign lastAddr = (addrQ == ADDR_W'(DEV_BYTES - 1));

  // pipeline that tracks the one-cycle read latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ <= 1'b0;
      endQ <= 1'b0;
    end else begin
      vldQ <= stb.issue;
      endQ <= stb.issue && (&addrQ[BLK_W-1:0]);
    end
  end

  assign sumNow = accQ + memData;
  assign blkBad = vldQ && endQ && (sumNow != 8'h00);

  // accumulator, restarted at every block boundary
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAcc) accQ <= 8'h00;
    else if (vldQ)           accQ <= endQ ? 8'h00 : sumNow;
  end

  p_acc_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (vldQ && endQ) |=> (accQ == 8'h00));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.issue && addrQ != '0) |-> ($past(stb.issue) && addrQ == $past(addrQ) + 1'b1));

  p_data_align_r9: assert property (@(posedge clk) disable iff (!rstN)
    vldQ |-> $past(memRe));
endmodule

// File: rtl/rom_sum_ctrl.sv
module rom_sum_ctrl
  import rom_sum_pkg::*;
#(
  parameter int NUM_DEV = 6,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NUM_DEV-1:0] devMask,
  input  logic               lastAddr,
  input  logic               blkBad,
  output dpStrobe_t          stb,
  output logic [IDX_W-1:0]   devIdx,
  output logic               done,
  output logic               pass,
  output logic               fail,
  output logic [IDX_W-1:0]   failDev
);
  ctrlState_t         stateQ;
  logic [NUM_DEV-1:0] maskQ;
  logic [IDX_W:0]     scanPtr;
  logic               nextFound;
  logic [IDX_W-1:0]   nextDev;

  // lowest installed device at or above the scan pointer
  always_comb begin
    nextFound = 1'b0;
    nextDev   = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (maskQ[i] && (i >= int'(scanPtr))) begin
        nextFound = 1'b1;
        nextDev   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    stb = '0;
    case (stateQ)
      ST_SCAN: begin
        stb.clrAddr = 1'b1;
        stb.clrAcc  = 1'b1;
      end
      ST_READ: begin
        stb.issue   = !blkBad;
        stb.incAddr = !blkBad && !lastAddr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      maskQ   <= '0;
      scanPtr <= '0;
      devIdx  <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      failDev <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (start) begin
          maskQ   <= devMask;
          scanPtr <= '0;
          done    <= 1'b0;
          pass    <= 1'b0;
          fail    <= 1'b0;
          failDev <= '0;
          stateQ  <= ST_SCAN;
        end
        ST_SCAN: begin
          if (nextFound) begin
            devIdx <= nextDev;
            stateQ <= ST_READ;
          end else begin
            done   <= 1'b1;
            pass   <= 1'b1;
            stateQ <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (blkBad) begin
            done    <= 1'b1;
            fail    <= 1'b1;
            failDev <= devIdx;
            stateQ  <= ST_IDLE;
          end else if (lastAddr) begin
            stateQ <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (blkBad) begin
            done    <= 1'b1;
            fail    <= 1'b1;
            failDev <= devIdx;
            stateQ  <= ST_IDLE;
          end else begin
            scanPtr <= (IDX_W+1)'(devIdx) + (IDX_W+1)'(1);
            stateQ  <= ST_SCAN;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  p_one_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({pass, fail}));

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(fail) && $stable(pass) && $stable(failDev)));

  p_quiet_after_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !stb.issue);

  p_fail_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> $past(blkBad));

  p_installed_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue |-> maskQ[devIdx]);
endmodule

// File: rtl/rom_sum_verifier.sv
module rom_sum_verifier
  import rom_sum_pkg::*;
#(
  parameter int NUM_DEV = 6,
  parameter int DEV_BYTES = 2048,
  parameter int BLK_BYTES = 512,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int ADDR_W = $clog2(DEV_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NUM_DEV-1:0] devMask,
  output logic               memRe,
  output logic [IDX_W-1:0]   memDev,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [7:0]         memData,
  output logic               done,
  output logic               pass,
  output logic               fail,
  output logic [IDX_W-1:0]   failDev
);
  dpStrobe_t stb;
  logic      lastAddr;
  logic      blkBad;

  rom_sum_ctrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .devMask(devMask),
    .lastAddr(lastAddr), .blkBad(blkBad), .stb(stb), .devIdx(memDev),
    .done(done), .pass(pass), .fail(fail), .failDev(failDev)
  );

  rom_sum_dp #(.DEV_BYTES(DEV_BYTES), .BLK_BYTES(BLK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memRe(memRe), .memAddr(memAddr),
    .memData(memData), .lastAddr(lastAddr), .blkBad(blkBad)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (!done && !pass && !fail && !memRe));
endmodule

// File: tb/tb_rom_sum_verifier.sv
module tb_rom_sum_verifier;
  localparam int PERIOD = 10;
  localparam int NDEV = 6;
  localparam int DBYTES = 16;
  localparam int BBYTES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NDEV-1:0] devMask = '0;
  logic memRe;
  logic [2:0] memDev;
  logic [3:0] memAddr;
  logic [7:0] memData;
  logic done, pass, fail;
  logic [2:0] failDev;

  int nTests = 0;
  int nFail = 0;
  bit flipOn = 0;
  int badDev = 0;
  int badAddr = 0;
  int badBit = 0;

  always #(PERIOD/2) clk = ~clk;

  rom_sum_verifier #(.NUM_DEV(NDEV), .DEV_BYTES(DBYTES), .BLK_BYTES(BBYTES)) dut (
    .clk(clk), .rstN(rstN), .start(start), .devMask(devMask), .memRe(memRe),
    .memDev(memDev), .memAddr(memAddr), .memData(memData), .done(done),
    .pass(pass), .fail(fail), .failDev(failDev)
  );

  function automatic logic [7:0] plainByte(int d, int a);
    return 8'((d * 37 + a * 11 + 5) & 255);
  endfunction

  // healthy image: last byte of each block cancels the rest
  function automatic logic [7:0] romByte(int d, int a);
    logic [7:0] s;
    int base;
    if ((a % BBYTES) != BBYTES - 1) return plainByte(d, a);
    s = 8'h00;
    base = a - (a % BBYTES);
    for (int k = 0; k < BBYTES - 1; k++) s = s + plainByte(d, base + k);
    return 8'h00 - s;
  endfunction

  always_ff @(posedge clk) begin
    if (memRe)
      memData <= romByte(int'(memDev), int'(memAddr)) ^
                 ((flipOn && int'(memDev) == badDev && int'(memAddr) == badAddr)
                  ? 8'(1 << badBit) : 8'h00);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  task automatic runOnce(input logic [NDEV-1:0] mask, input bit flip,
                         input int bDev, input int bAddr);
    int expSeq[8];
    int expN;
    int seq[8];
    int seqN;
    int cnt;
    int lastD;
    int nextA;
    bit addrOk;
    bit expFail;
    logic [2:0] heldDev;
    flipOn = flip; badDev = bDev; badAddr = bAddr; badBit = (bAddr + bDev) % 8;
    expFail = flip && mask[bDev];
    expN = 0;
    for (int i = 0; i < NDEV; i++)
      if (mask[i] && (!expFail || i <= bDev)) begin expSeq[expN] = i; expN++; end
    @(negedge clk); devMask = mask; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done, "R8 start clears done", int'(done), 0);
    cnt = 0; seqN = 0; lastD = -1; nextA = 0; addrOk = 1;
    while (!done && cnt < 2000) begin
      if (memRe) begin
        if (int'(memDev) != lastD) begin
          if (seqN < 8) seq[seqN] = int'(memDev);
          seqN++; lastD = int'(memDev);
          if (memAddr != 0) addrOk = 0;
        end else if (int'(memAddr) != nextA) addrOk = 0;
        nextA = int'(memAddr) + 1;
      end
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    chk(done, "R3/R4 run finishes", int'(done), 1);
    chk(addrOk, "R2 contiguous addresses from 0", int'(addrOk), 1);
    chk(seqN == expN, "R2/R5 device count visited", seqN, expN);
    for (int i = 0; i < expN && i < seqN; i++)
      chk(seq[i] == expSeq[i], "R2 device order", seq[i], expSeq[i]);
    chk(pass ^ fail, "R10 exactly one result", int'({pass, fail}), 1);
    if (expFail) begin
      chk(fail, "R4 fail on bit flip", int'(fail), 1);
      chk(int'(failDev) == bDev, "R4 failing device index", int'(failDev), bDev);
    end else begin
      chk(pass, "R3 pass on clean image", int'(pass), 1);
      chk(cnt == expN * (DBYTES + 2) + 1, "R7/R6 pass latency", cnt, expN * (DBYTES + 2) + 1);
    end
    heldDev = failDev;
    repeat (4) begin
      @(negedge clk);
      if (memRe) addrOk = 0;
    end
    chk(done && (fail == expFail) && failDev == heldDev && addrOk,
        "R8/R5 result held, no reads", int'(failDev), int'(heldDev));
  endtask

  initial begin
    #(PERIOD * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !pass && !fail && !memRe, "R1 reset state",
        int'({done, pass, fail, memRe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !memRe, "R1 idle after reset", int'({done, memRe}), 0);
    // R6 empty mask first, then every mask on a clean image (R3, R7)
    for (int m = 0; m < (1 << NDEV); m++) runOnce(NDEV'(m), 1'b0, 0, 0);
    // R4/R5 single-bit flip at every address of every device
    for (int d = 0; d < NDEV; d++)
      for (int a = 0; a < DBYTES; a++) runOnce('1, 1'b1, d, a);
    // R2 corruption in a device left out of the mask is never seen
    for (int d = 0; d < NDEV; d++) runOnce(~(NDEV'(1) << d), 1'b1, d, d % DBYTES);
    finishRun();
  end
endmodule